// File: doc/BRIEF.md
# Display Power Sequencing Controller

This block takes a raster display pipeline down and brings it back up in a fixed, safe order. It drives the enable requests of three pixel DMA channels, the freeze request of the raster counter and the run request of the dot clock. For each of these it watches the matching status line, and it also watches the current beam line. A single-cycle `start_off` or `start_on` pulse starts a sequence. While the sequence runs, `busy` is high. A one-cycle `done` pulse marks the end, and a sticky bit vector records which confirm steps ran out of polls.

Shutdown runs in this order:
1. Drop every DMA enable and wait until all three channels report idle.
2. Wait for the beam to reach the programmed pixel-enable-off line.
3. Freeze the raster counter.
4. Stop the dot clock.
5. Give the frame FIFO a one-cycle reset pulse.

Startup runs the reverse subset: clock on, counter released, frame DMA on.

Each step is confirmed before the next one begins. A sequence whose purpose is already met is skipped: shutdown while the counter is frozen, or startup while it is running. All pins are plain level control and status. No data flows through the block, so it has no valid/ready interface. The only command handshake is that a pulse arriving while `busy` is high is dropped.

Top module: `disp_pwr_seq`

## Requirements
- R1: Out of reset, `dma_en_req` is 0, `freeze_req` is 1, `clk_run_req` is 0, `fifo_rst`, `busy` and `done` are 0, and `err_flags` is 0.
- R2: Shutdown clears all three DMA enable bits (bit 0 overlay, bit 1 frame, bit 2 display-ID). It then waits until `dma_active` is all zero before it starts watching the beam.
- R3: After the DMA step, `freeze_req` rises in the cycle after the one in which `beam_y` equals `vpix_off_line`.
- R4: `clk_run_req` falls only after `frozen_sts` confirms the freeze. `fifo_rst` rises only after `clk_running` confirms the clock stopped.
- R5: `fifo_rst` is high for exactly one cycle per shutdown, and it is the last shutdown step.
- R6: Startup sets `clk_run_req` and waits for `clk_running`. It then drops `freeze_req` and waits for `frozen_sts` low. Finally it sets only `dma_en_req` bit 1 and waits for `dma_active` bit 1.
- R7: `start_off` with `frozen_sts` high, or `start_on` with `frozen_sts` low, changes no control output and never raises `busy`. It gives `done` one cycle later.
- R8: Each confirm step polls at most POLL_LIMIT cycles, and the beam-line wait polls at most LINE_LIMIT cycles. On expiry the step sets its error bit and the sequence carries on. The error bits are:
  - bit 0: DMA stop
  - bit 1: beam line
  - bit 2: freeze
  - bit 3: clock stop
  - bit 4: clock start
  - bit 5: unfreeze
  - bit 6: frame DMA start
- R9: Error bits stay set after the sequence ends, until the next accepted command, which clears them.
- R10: A command pulse while `busy` is high is ignored. If `start_off` and `start_on` arrive together, shutdown wins.
- R11: `done` is a single-cycle pulse, exactly one per accepted command. `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_off | input | 1 | Shutdown command pulse |
| start_on | input | 1 | Startup command pulse |
| vpix_off_line | input | YW | Beam line at which the counter is frozen |
| beam_y | input | YW | Current raster line |
| dma_en_req | output | 3 | DMA enables: bit0 overlay, bit1 frame, bit2 display-ID |
| dma_active | input | 3 | DMA channel status, same bit order |
| freeze_req | output | 1 | Raster counter freeze request |
| frozen_sts | input | 1 | Raster counter reports frozen |
| clk_run_req | output | 1 | Dot-clock run request |
| clk_running | input | 1 | Dot clock reports running |
| fifo_rst | output | 1 | Frame DMA FIFO reset pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err_flags | output | 7 | Sticky per-step timeout flags |

## Verification
The bench builds the block with YW=6, POLL_LIMIT=16 and LINE_LIMIT=64, and it wraps the beam every 40 lines. These small values make every timeout reachable within tens of cycles. The bench sweeps all eight combinations of fast (2-cycle) and slow (30-cycle) acknowledge latency for the DMA, freeze and clock models. For each combination it predicts which error bits must appear in both directions. An unreachable off-line of 50 drives the beam wait to expiry. Short latencies also let the skip, dropped-command and simultaneous-command cases run back to back.

// File: rtl/dps_pkg.sv
package dps_pkg;

  localparam int DMA_N  = 3;
  localparam int CH_OVL = 0;
  localparam int CH_FRM = 1;
  localparam int CH_DID = 2;

  localparam int ERR_N       = 7;
  localparam int E_DMA_STOP  = 0;
  localparam int E_LINE      = 1;
  localparam int E_FREEZE    = 2;
  localparam int E_CLK_STOP  = 3;
  localparam int E_CLK_START = 4;
  localparam int E_THAW      = 5;
  localparam int E_DMA_START = 6;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OFF_DMA,
    ST_OFF_LINE,
    ST_OFF_FRZ,
    ST_OFF_CLK,
    ST_OFF_FIFO,
    ST_ON_CLK,
    ST_ON_THAW,
    ST_ON_DMA
  } seq_state_e;

endpackage

// File: rtl/dps_poll_timer.sv
module dps_poll_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          last
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign last = (cnt == limit - 1'b1);

endmodule

// File: rtl/dps_err_bank.sv
module dps_err_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || clr) flags[g] <= 1'b0;
      else if (set[g])   flags[g] <= 1'b1;
    end
  end

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import dps_pkg::*;
#(
  parameter int YW         = 11,
  parameter int POLL_LIMIT = 10000,
  parameter int LINE_LIMIT = 100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_off,
  input  logic               start_on,
  input  logic [YW-1:0]      vpix_off_line,
  input  logic [YW-1:0]      beam_y,
  output logic [DMA_N-1:0]   dma_en_req,
  input  logic [DMA_N-1:0]   dma_active,
  output logic               freeze_req,
  input  logic               frozen_sts,
  output logic               clk_run_req,
  input  logic               clk_running,
  output logic               fifo_rst,
  output logic               busy,
  output logic               done,
  output logic [ERR_N-1:0]   err_flags
);

  localparam int MAXL = (LINE_LIMIT > POLL_LIMIT) ? LINE_LIMIT : POLL_LIMIT;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] POLL_L = CW'(POLL_LIMIT);
  localparam logic [CW-1:0] LINE_L = CW'(LINE_LIMIT);

  seq_state_e       state;
  logic             waiting;
  logic             cond;
  logic             expired;
  logic             advance;
  logic [CW-1:0]    limit;
  logic [ERR_N-1:0] err_set;
  logic [ERR_N-1:0] step_bit;
  logic             accept;

  // Step decode: what the current wait state is polling for
  always_comb begin
    waiting  = 1'b1;
    cond     = 1'b0;
    limit    = POLL_L;
    step_bit = '0;
    unique case (state)
      ST_OFF_DMA:  begin cond = (dma_active == '0);        step_bit[E_DMA_STOP]  = 1'b1; end
      ST_OFF_LINE: begin cond = (beam_y == vpix_off_line); step_bit[E_LINE]      = 1'b1;
                         limit = LINE_L; end
      ST_OFF_FRZ:  begin cond = frozen_sts;                step_bit[E_FREEZE]    = 1'b1; end
      ST_OFF_CLK:  begin cond = !clk_running;              step_bit[E_CLK_STOP]  = 1'b1; end
      ST_ON_CLK:   begin cond = clk_running;               step_bit[E_CLK_START] = 1'b1; end
      ST_ON_THAW:  begin cond = !frozen_sts;               step_bit[E_THAW]      = 1'b1; end
      ST_ON_DMA:   begin cond = dma_active[CH_FRM];        step_bit[E_DMA_START] = 1'b1; end
      default:     waiting = 1'b0;
    endcase
  end

  assign advance = waiting && (cond || expired);
  assign err_set = (waiting && !cond && expired) ? step_bit : '0;
  assign accept  = (state == ST_IDLE) && (start_off || start_on);
  assign busy    = (state != ST_IDLE);

  dps_poll_timer #(.CW(CW)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!waiting || advance),
    .limit (limit),
    .last  (expired)
  );

  dps_err_bank #(.N(ERR_N)) i_err (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .set   (err_set),
    .flags (err_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      dma_en_req  <= '0;
      freeze_req  <= 1'b1;
      clk_run_req <= 1'b0;
      fifo_rst    <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_off) begin
            if (frozen_sts) done <= 1'b1;
            else begin
              dma_en_req <= '0;
              state      <= ST_OFF_DMA;
            end
          end else if (start_on) begin
            if (!frozen_sts) done <= 1'b1;
            else begin
              clk_run_req <= 1'b1;
              state       <= ST_ON_CLK;
            end
          end
        end
        ST_OFF_DMA:  if (advance) state <= ST_OFF_LINE;
        ST_OFF_LINE: if (advance) begin
          freeze_req <= 1'b1;
          state      <= ST_OFF_FRZ;
        end
        ST_OFF_FRZ:  if (advance) begin
          clk_run_req <= 1'b0;
          state       <= ST_OFF_CLK;
        end
        ST_OFF_CLK:  if (advance) begin
          fifo_rst <= 1'b1;
          state    <= ST_OFF_FIFO;
        end
        ST_OFF_FIFO: begin
          fifo_rst <= 1'b0;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_ON_CLK:   if (advance) begin
          freeze_req <= 1'b0;
          state      <= ST_ON_THAW;
        end
        ST_ON_THAW:  if (advance) begin
          dma_en_req[CH_FRM] <= 1'b1;
          state              <= ST_ON_DMA;
        end
        ST_ON_DMA:   if (advance) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dps_chk.sv
module dps_chk
  import dps_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [DMA_N-1:0] dma_en_req,
  input logic             freeze_req,
  input logic             clk_run_req,
  input logic             fifo_rst,
  input logic             busy,
  input logic             done,
  input logic [ERR_N-1:0] err_flags
);

  // R2
  frz_after_dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze_req) |-> (dma_en_req == '0));

  // R4
  clk_stop_after_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_run_req) |-> freeze_req);

  // R5
  fifo_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> !fifo_rst);

  // R5
  fifo_clk_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |-> (!clk_run_req && freeze_req && dma_en_req == '0));

  // R6
  thaw_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freeze_req) |-> clk_run_req);

  // R6
  frame_dma_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_en_req[CH_FRM]) |-> (clk_run_req && !freeze_req));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  err_clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (err_flags == '0));

endmodule

bind disp_pwr_seq dps_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dma_en_req  (dma_en_req),
  .freeze_req  (freeze_req),
  .clk_run_req (clk_run_req),
  .fifo_rst    (fifo_rst),
  .busy        (busy),
  .done        (done),
  .err_flags   (err_flags)
);

// File: tb/test_disp_pwr_seq.sv
module test_disp_pwr_seq;

  localparam int YW   = 6;
  localparam int PL   = 16;
  localparam int LL   = 64;
  localparam int YTOP = 40;
  localparam int FAST = 2;
  localparam int SLOW = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_off = 1'b0;
  logic          start_on = 1'b0;
  logic [YW-1:0] vpix_off_line = '0;
  logic [YW-1:0] beam_y;
  logic [2:0]    dma_en_req;
  logic          freeze_req, clk_run_req, fifo_rst, busy, done;
  logic [6:0]    err_flags;
  logic [4:0]    fb;
  logic [4:0]    req;
  int            lat [5];
  int            lcnt [5];

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  disp_pwr_seq #(.YW(YW), .POLL_LIMIT(PL), .LINE_LIMIT(LL)) i_disp_pwr_seq (
    .clk(clk), .rst_n(rst_n), .start_off(start_off), .start_on(start_on),
    .vpix_off_line(vpix_off_line), .beam_y(beam_y),
    .dma_en_req(dma_en_req), .dma_active(fb[2:0]),
    .freeze_req(freeze_req), .frozen_sts(fb[3]),
    .clk_run_req(clk_run_req), .clk_running(fb[4]),
    .fifo_rst(fifo_rst), .busy(busy), .done(done), .err_flags(err_flags)
  );

  assign req = {clk_run_req, freeze_req, dma_en_req};

  // delayed-acknowledge models and beam counter
  always @(posedge clk) begin
    if (!rst_n) begin
      fb     <= 5'b01000;
      beam_y <= '0;
      for (int i = 0; i < 5; i++) lcnt[i] <= 0;
    end else begin
      for (int i = 0; i < 5; i++) begin
        if (fb[i] != req[i]) begin
          if (lcnt[i] >= lat[i]) begin fb[i] <= req[i]; lcnt[i] <= 0; end
          else lcnt[i] <= lcnt[i] + 1;
        end else lcnt[i] <= 0;
      end
      if (fb[4] && !fb[3]) beam_y <= (beam_y == YW'(YTOP - 1)) ? '0 : beam_y + 1'b1;
    end
  end

  // monitor, samples at negedge
  int            n_done, n_fifo;
  logic          seen_busy;
  logic [YW-1:0] frz_beam;
  logic          clk_fall_frz, dma_rise_ok;
  logic          pv_frz, pv_clk, pv_fdma, pv_frozen, pv_run;
  logic [YW-1:0] pv_beam;

  always @(negedge clk) begin
    if (done) n_done++;
    if (fifo_rst) n_fifo++;
    if (busy) seen_busy = 1'b1;
    if (freeze_req && !pv_frz) frz_beam = pv_beam;
    if (!clk_run_req && pv_clk) clk_fall_frz = pv_frozen;
    if (dma_en_req[1] && !pv_fdma) dma_rise_ok = pv_run && !pv_frozen;
    pv_frz = freeze_req; pv_clk = clk_run_req; pv_fdma = dma_en_req[1];
    pv_frozen = fb[3]; pv_run = fb[4]; pv_beam = beam_y;
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_mon();
    n_done = 0; n_fifo = 0; seen_busy = 1'b0;
    frz_beam = '1; clk_fall_frz = 1'b0; dma_rise_ok = 1'b0;
  endtask

  task automatic pulse(input bit off, input bit on);
    @(negedge clk);
    start_off = off; start_on = on;
    @(negedge clk);
    start_off = 1'b0; start_on = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && n_done == 0; i++) @(negedge clk);
    wait_cyc(3);
  endtask

  task automatic set_lat(input int d, input int f, input int c);
    lat[0] = d; lat[1] = d; lat[2] = d; lat[3] = f; lat[4] = c;
  endtask

  task automatic check_off_state(input string tag);
    check(dma_en_req == 3'b000, {tag, " dma_en_req off"}, dma_en_req, 0);
    check(freeze_req == 1'b1, {tag, " freeze_req off"}, freeze_req, 1);
    check(clk_run_req == 1'b0, {tag, " clk_run_req off"}, clk_run_req, 0);
  endtask

  task automatic check_on_state(input string tag);
    check(dma_en_req == 3'b010, {tag, " dma_en_req on"}, dma_en_req, 2);
    check(freeze_req == 1'b0, {tag, " freeze_req on"}, freeze_req, 0);
    check(clk_run_req == 1'b1, {tag, " clk_run_req on"}, clk_run_req, 1);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_lat(FAST, FAST, FAST);
    clear_mon();
    pv_frz = 1'b1; pv_clk = 1'b0; pv_fdma = 1'b0; pv_frozen = 1'b1; pv_run = 1'b0; pv_beam = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    check_off_state("R1");
    check({fifo_rst, busy, done} == 3'b000, "R1 fifo_rst/busy/done", {fifo_rst, busy, done}, 0);
    check(err_flags == 0, "R1 err_flags", err_flags, 0);

    for (int k = 0; k < 8; k++) begin
      automatic bit sd = k[0], sf = k[1], sc = k[2];
      automatic logic [6:0] exp_on = {sd, sf, sc, 4'b0000};
      automatic logic [6:0] exp_off = {3'b000, sc, sf, 1'b0, sd};
      automatic logic [YW-1:0] line = YW'(5 + 4 * k);
      set_lat(sd ? SLOW : FAST, sf ? SLOW : FAST, sc ? SLOW : FAST);
      // startup
      clear_mon();
      pulse(1'b0, 1'b1);
      wait_done();
      check(n_done == 1, "R11 one done per startup", n_done, 1);
      check(err_flags == exp_on, "R8 startup timeout flags", err_flags, exp_on);
      if (k == 0) check(dma_rise_ok, "R6 frame DMA after clock and thaw", dma_rise_ok, 1);
      wait_cyc(120);
      check(err_flags == exp_on, "R9 startup flags sticky", err_flags, exp_on);
      check_on_state("R6");
      // shutdown
      vpix_off_line = line;
      clear_mon();
      pulse(1'b1, 1'b0);
      wait_done();
      check(n_done == 1, "R11 one done per shutdown", n_done, 1);
      check(n_fifo == 1, "R5 fifo reset one cycle", n_fifo, 1);
      check(err_flags == exp_off, "R8 shutdown timeout flags", err_flags, exp_off);
      check(frz_beam == line, "R3 freeze at off line", frz_beam, line);
      if (!sf) check(clk_fall_frz, "R4 clock stop after freeze", clk_fall_frz, 1);
      check_off_state("R2");
      wait_cyc(120);
      check(err_flags == exp_off, "R9 shutdown flags sticky", err_flags, exp_off);
    end

    // beam line never reached
    set_lat(FAST, FAST, FAST);
    clear_mon(); pulse(1'b0, 1'b1); wait_done(); wait_cyc(20);
    vpix_off_line = YW'(50);
    clear_mon(); pulse(1'b1, 1'b0); wait_done();
    check(err_flags == 7'b0000010, "R8 beam line timeout", err_flags, 2);
    check_off_state("R8");
    wait_cyc(20);

    // skip shutdown when already frozen; clears sticky flags
    clear_mon(); pulse(1'b1, 1'b0); wait_cyc(4);
    check(n_done == 1, "R7 skipped shutdown done", n_done, 1);
    check(!seen_busy, "R7 skipped shutdown no busy", seen_busy, 0);
    check(n_fifo == 0, "R7 skipped shutdown no fifo reset", n_fifo, 0);
    check(err_flags == 0, "R9 flags cleared by command", err_flags, 0);
    check_off_state("R7");

    // skip startup when already running
    vpix_off_line = YW'(7);
    clear_mon(); pulse(1'b0, 1'b1); wait_done(); wait_cyc(20);
    clear_mon(); pulse(1'b0, 1'b1); wait_cyc(4);
    check(n_done == 1, "R7 skipped startup done", n_done, 1);
    check(!seen_busy, "R7 skipped startup no busy", seen_busy, 0);
    check_on_state("R7");

    // command during busy ignored
    clear_mon(); pulse(1'b1, 1'b0); wait_cyc(2);
    pulse(1'b0, 1'b1);
    wait_done(); wait_cyc(40);
    check(n_done == 1, "R10 busy command ignored done count", n_done, 1);
    check_off_state("R10");

    // simultaneous commands: shutdown wins
    clear_mon(); pulse(1'b0, 1'b1); wait_done(); wait_cyc(20);
    clear_mon(); pulse(1'b1, 1'b1); wait_done(); wait_cyc(20);
    check(n_fifo == 1, "R10 simultaneous runs shutdown", n_fifo, 1);
    check_off_state("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule